// File: doc/BRIEF.md
# Search Step Sequencer for a Single-Wire Bus

This block runs one branch step of the device-address search on a single-wire bus. It does not time the bus itself. It hands each bit slot to a separate bit-slot engine through a request/done handshake. A step is made of two read slots, an address bit and then its complement, and in most cases one write slot that sends back the chosen direction.

The controller above it keeps the 64-bit search path and the last-discrepancy position. For each step it supplies the direction to take when both branches are populated. It then receives a 3-bit result: the two bits read and the direction taken. From that result it can tell a clean branch point, a forced path, or an empty bus that calls for a restart.

Top module: `ow_search_step`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `slot_req_o` are 0 and `status_o` is 3'b000. No slot is requested while `busy_o` is 0.
- R2: A `start_i` accepted while idle issues exactly two read slots (`slot_op_o`=0). The first returned `slot_rbit_i` is the address bit and the second is the complement bit. Only one slot is outstanding at a time. The engine answers a request no earlier than the cycle after it.
- R3: Result layout is `status_o[0]` = address bit, `status_o[1]` = complement bit and `status_o[2]` = direction taken. The only exception is the all-ones case of R4.
- R4: If both read bits are 1, the result is 3'b011, no write slot is issued, and the step ends.
- R5: If both read bits are 0, the captured preferred direction is written. The result is 3'b100 when that direction is 1 and 3'b000 when it is 0.
- R6: If exactly one read bit is 1, the direction written is the address bit. The result is 3'b101 when the address bit is 1 and 3'b010 when the complement bit is 1.
- R7: The direction is sent as a single write slot (`slot_op_o`=1, bit on `slot_wbit_o`), issued only after both reads have completed.
- R8: `pref_dir_i` is captured in the cycle `start_i` is accepted. Later changes do not affect that step.
- R9: `status_o` keeps its value from `done_o` until the next accepted start. A `start_i` raised while `busy_o` is 1 is ignored and starts no further step.
- R10: `done_o` is a one-cycle pulse. It comes one cycle after the write slot completes, or two cycles after the complement read completes when no write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one search step (taken only when idle) |
| pref_dir_i | input | 1 | Direction to take when both branches exist |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | {direction, complement bit, address bit} |
| slot_req_o | output | 1 | One-cycle request for a bit slot |
| slot_op_o | output | 1 | Slot kind: 0 read, 1 write |
| slot_wbit_o | output | 1 | Bit to send on a write slot |
| slot_done_i | input | 1 | Bit-slot engine finished the current slot |
| slot_rbit_i | input | 1 | Sampled bus level of a finished read slot |

## Verification
The bound checker watches the slot handshake on every cycle. It confirms that only one slot is outstanding and that a write never precedes the second read. It checks that the write bit matches the reported direction, that the all-ones result comes with no write while every other result comes with exactly one, that `done_o` is a single pulse, and that the result holds while idle. Only the bench scenarios can show the mapping from the bits read to the exact result and direction for every combination, the capture of the preferred direction against a later change, and that a start raised mid-step never produces a second step.

// File: rtl/ow_search_pkg.sv
package ow_search_pkg;
  localparam int unsigned STAT_W  = 3;
  localparam int unsigned ID_POS  = 0;
  localparam int unsigned CMP_POS = 1;
  localparam int unsigned DIR_POS = 2;

  localparam logic SLOT_RD = 1'b0;
  localparam logic SLOT_WR = 1'b1;

  typedef logic [STAT_W-1:0] stat_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID_REQ,
    ST_ID_WAIT,
    ST_CMP_REQ,
    ST_CMP_WAIT,
    ST_EVAL,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_FIN
  } step_state_e;
endpackage

// File: rtl/ow_search_decide.sv
module ow_search_decide
  import ow_search_pkg::*;
(
  input  logic  id_bit_i,
  input  logic  cmp_bit_i,
  input  logic  pref_i,
  output logic  dir_o,
  output logic  abort_o,
  output stat_t status_o
);
  always_comb begin
    abort_o  = id_bit_i & cmp_bit_i;
    // disagreeing bits force the path; agreeing zeros take the preference
    dir_o    = (id_bit_i ^ cmp_bit_i) ? id_bit_i : pref_i;
    status_o = '0;
    status_o[ID_POS]  = id_bit_i;
    status_o[CMP_POS] = cmp_bit_i;
    status_o[DIR_POS] = abort_o ? 1'b0 : dir_o;
  end
endmodule

// File: rtl/ow_search_seq.sv
module ow_search_seq
  import ow_search_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  pref_dir_i,
  input  logic  slot_done_i,
  input  logic  slot_rbit_i,
  input  logic  abort_i,
  input  stat_t status_n_i,
  output logic  id_q_o,
  output logic  cmp_q_o,
  output logic  pref_q_o,
  output stat_t status_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  slot_req_o,
  output logic  slot_op_o,
  output logic  slot_wbit_o
);
  step_state_e state_q, state_d;
  logic  id_q, cmp_q, pref_q;
  stat_t status_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_ID_REQ;
      ST_ID_REQ:   state_d = ST_ID_WAIT;
      ST_ID_WAIT:  if (slot_done_i) state_d = ST_CMP_REQ;
      ST_CMP_REQ:  state_d = ST_CMP_WAIT;
      ST_CMP_WAIT: if (slot_done_i) state_d = ST_EVAL;
      ST_EVAL:     state_d = abort_i ? ST_FIN : ST_WR_REQ;
      ST_WR_REQ:   state_d = ST_WR_WAIT;
      ST_WR_WAIT:  if (slot_done_i) state_d = ST_FIN;
      ST_FIN:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      id_q     <= 1'b0;
      cmp_q    <= 1'b0;
      pref_q   <= 1'b0;
      status_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) pref_q <= pref_dir_i;
      if (state_q == ST_ID_WAIT && slot_done_i) id_q <= slot_rbit_i;
      if (state_q == ST_CMP_WAIT && slot_done_i) cmp_q <= slot_rbit_i;
      if (state_q == ST_EVAL) status_q <= status_n_i;
    end
  end

  assign id_q_o      = id_q;
  assign cmp_q_o     = cmp_q;
  assign pref_q_o    = pref_q;
  assign status_o    = status_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign slot_req_o  = (state_q == ST_ID_REQ) || (state_q == ST_CMP_REQ) ||
                       (state_q == ST_WR_REQ);
  assign slot_op_o   = (state_q == ST_WR_REQ) ? SLOT_WR : SLOT_RD;
  assign slot_wbit_o = (state_q == ST_WR_REQ) ? status_q[DIR_POS] : 1'b0;
endmodule

// File: rtl/ow_search_step.sv
module ow_search_step
  import ow_search_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pref_dir_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [STAT_W-1:0] status_o,
  output logic              slot_req_o,
  output logic              slot_op_o,
  output logic              slot_wbit_o,
  input  logic              slot_done_i,
  input  logic              slot_rbit_i
);
  logic  id_q, cmp_q, pref_q, dir, abort;
  stat_t status_n;

  ow_search_decide u_decide (
    .id_bit_i  (id_q),
    .cmp_bit_i (cmp_q),
    .pref_i    (pref_q),
    .dir_o     (dir),
    .abort_o   (abort),
    .status_o  (status_n)
  );

  ow_search_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pref_dir_i  (pref_dir_i),
    .slot_done_i (slot_done_i),
    .slot_rbit_i (slot_rbit_i),
    .abort_i     (abort),
    .status_n_i  (status_n),
    .id_q_o      (id_q),
    .cmp_q_o     (cmp_q),
    .pref_q_o    (pref_q),
    .status_o    (status_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .slot_req_o  (slot_req_o),
    .slot_op_o   (slot_op_o),
    .slot_wbit_o (slot_wbit_o)
  );

  logic unused_dir;
  assign unused_dir = dir;
endmodule

// File: rtl/ow_search_step_chk.sv
module ow_search_step_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] status_o,
  input logic       slot_req_o,
  input logic       slot_op_o,
  input logic       slot_wbit_o,
  input logic       slot_done_i
);
  logic [1:0] rd_cnt, wr_cnt;
  logic       outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
      outstanding <= 1'b0;
    end else begin
      if (start_i && !busy_o) begin
        rd_cnt <= '0;
        wr_cnt <= '0;
      end else if (slot_req_o) begin
        if (slot_op_o) wr_cnt <= wr_cnt + 2'd1;
        else           rd_cnt <= rd_cnt + 2'd1;
      end
      if (slot_req_o)       outstanding <= 1'b1;
      else if (slot_done_i) outstanding <= 1'b0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !slot_req_o);
  p_one_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> !outstanding);
  p_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o[1:0] == 2'b11) |-> (wr_cnt == 2'd0));
  p_one_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o[1:0] != 2'b11) |-> (wr_cnt == 2'd1));
  p_dir_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_req_o && slot_op_o) |-> (slot_wbit_o == status_o[2]));
  p_write_after_reads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_req_o && slot_op_o) |-> (rd_cnt == 2'd2));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(status_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind ow_search_step ow_search_step_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .slot_req_o  (slot_req_o),
  .slot_op_o   (slot_op_o),
  .slot_wbit_o (slot_wbit_o),
  .slot_done_i (slot_done_i)
);

// File: tb/ow_search_step_test.sv
module ow_search_step_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pref = 1'b0, sdone = 1'b0, srbit = 1'b0;
  logic busy, done, sreq, sop, swbit;
  logic [2:0] status;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ow_search_step uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pref_dir_i(pref),
    .busy_o(busy), .done_o(done), .status_o(status),
    .slot_req_o(sreq), .slot_op_o(sop), .slot_wbit_o(swbit),
    .slot_done_i(sdone), .slot_rbit_i(srbit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one step; engine answers lat cycles after each request
  task automatic run_step(input bit id, input bit cmp, input bit p, input int lat,
                          input bit flip, input bit poke);
    int nrd = 0, nwr = 0, wbit = -1, order_bad = 0, extra = 0, cyc = 0;
    bit got = 0;
    logic [2:0] st = '0, exp;
    bit dir;
    @(negedge clk);
    start = 1'b1; pref = p;
    @(negedge clk);
    start = 1'b0;
    if (flip) pref = ~p;
    while (!got && cyc < 100) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      sdone = 1'b0;
      if (poke && cyc == 3) start = 1'b1; else if (poke) start = 1'b0;
      if (done) begin got = 1; st = status; end
      else if (sreq) begin
        if (sop) begin nwr++; wbit = swbit; if (nrd != 2) order_bad++; end
        else nrd++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          cyc++;
          if (poke && cyc == 3) start = 1'b1; else if (poke) start = 1'b0;
          if (sreq) extra++;
        end
        srbit = (nrd == 1 && !sop) ? id : cmp;
        sdone = 1'b1;
      end
    end
    start = 1'b0;
    sdone = 1'b0;
    dir = (id ^ cmp) ? id : p;
    exp = (id & cmp) ? 3'b011 : {dir, cmp, id};
    chk(got, "R10 done seen", got, 1);
    chk(st == exp, (id & cmp) ? "R4 status" : (id ^ cmp) ? "R6 status" :
        (flip ? "R8 status" : "R5 status"), st, exp);
    chk(nrd == 2 && extra == 0, "R2 read slots", nrd, 2);
    chk(nwr == ((id & cmp) ? 0 : 1) && order_bad == 0, "R7 write slots", nwr,
        (id & cmp) ? 0 : 1);
    if (!(id & cmp)) chk(wbit == int'(dir), "R3 written dir", wbit, dir);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    pref = ~pref;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (sreq || busy) extra++;
    end
    chk(status == exp && extra == 0, "R9 hold and no extra step", status, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sreq && status == 3'b000, "R1 reset state", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !sreq, "R1 idle after reset", {busy, sreq}, 0);
    for (int m = 0; m < 32; m++)
      run_step(m[0], m[1], m[2], m[3] ? 3 : 1, m[4], 1'b0);
    run_step(1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b1);
    run_step(1'b1, 1'b0, 1'b0, 2, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule